// File: doc/BRIEF.md
# Saturating up/down counter field

This block is the counting part of a hardware-updated register field. It has an increment request and a decrement request. The step size for each direction is fixed when the block is built. It can be a constant, an amount supplied on an input port of configured width, or nothing at all, which removes that direction. Each cycle the block computes a candidate value from the current field contents and the active requests. It checks the candidate against an optional upper limit and an optional lower limit, and raises an update strobe only when every enabled limit is met. A register stage loads the candidate on the next clock edge, and only when the strobe is high.

A limit is a guard, not a clamp. An update that would cross a limit is dropped as a whole, and the field keeps its old value. With no limits enabled the field wraps modulo 2^FIELD_W.

Elaboration rejects illegal configurations:
- both directions removed;
- a direction given both a fixed step and a port width;
- a port wider than the field.

Top module: `sat_updown_field`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `value` loads RESET_VAL (5 in the default build). After release the field keeps that value until an update passes.
- R2: A direction with no fixed step and no port width steps by exactly 1. In the default build this is the decrement direction.
- R3: A direction with a port width and no fixed step adds the unsigned amount on its port of that width. In the default build this is the 3-bit `inc_amt`.
- R4: A direction whose fixed step is 0 is removed. Its request alone leaves `update` low and `value` unchanged.
- R5: A direction with a fixed nonzero step uses that constant and ignores its amount port.
- R6: With an upper limit enabled, a candidate is accepted only if it is at or below the limit. "Full" means all ones for the field width, and a numeric setting uses that number. Otherwise `update` stays low and `value` holds, without clamping.
- R7: With a lower limit enabled, a candidate is accepted only if it is at or above the limit, and "full" means 0. Otherwise `update` stays low and `value` holds.
- R8: With both requests active, the candidate is the current value plus the increment step minus the decrement step. That candidate must meet every enabled limit at once.
- R9: `update` is combinational in the same cycle as the requests. `value` takes the candidate at the next rising edge only if `update` was high, and holds otherwise.
- R10: With no limits enabled, the field wraps modulo 2^FIELD_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inc_req | input | 1 | Increment request |
| inc_amt | input | INC_PORT_W | Increment amount, used only in port mode |
| dec_req | input | 1 | Decrement request |
| dec_amt | input | DEC_PORT_W | Decrement amount, used only in port mode |
| value | output | FIELD_W | Current field contents |
| update | output | 1 | Strobe: candidate passed every enabled limit this cycle |

## Verification
The strobe has no register on its path, so the bench reads it one time unit after it drives the requests on a falling edge, within the same cycle. The field value passes through one register. The bench therefore reads it one time unit after the following rising edge, before the next falling edge changes the inputs again. Reset is synchronous, so its effect is read after the edge that samples it. Blocked updates are confirmed by reading the unchanged value at that same point.

// File: rtl/sud_pkg.sv
package sud_pkg;

   typedef enum logic [1:0] {
      STEP_NONE,
      STEP_CONST,
      STEP_PORT
   } step_kind_e;

   typedef enum logic [1:0] {
      SAT_OFF,
      SAT_FULL,
      SAT_VALUE
   } sat_mode_e;

   // value < 0 : not set ; value == 0 : removed ; width == 0 : not set
   function automatic step_kind_e pick_kind(input int value, input int width);
      if (value == 0)      return STEP_NONE;
      else if (value > 0)  return STEP_CONST;
      else if (width > 0)  return STEP_PORT;
      else                 return STEP_CONST;
   endfunction

   function automatic int const_step(input int value);
      return (value > 0) ? value : 1;
   endfunction

   function automatic int upper_limit(input sat_mode_e mode, input int lim, input int w);
      if (mode == SAT_FULL) return (1 << w) - 1;
      return lim;
   endfunction

   function automatic int lower_limit(input sat_mode_e mode, input int lim);
      if (mode == SAT_FULL) return 0;
      return lim;
   endfunction

endpackage

// File: rtl/sud_step_sel.sv
module sud_step_sel #(
   parameter int FIELD_W   = 4,
   parameter int STEP_VAL  = -1,
   parameter int STEP_WID  = 0,
   parameter int PORT_W    = 1
) (
   input  logic               req,
   input  logic [PORT_W-1:0]  amt,
   output logic [FIELD_W:0]   step,
   output logic               active
);
   import sud_pkg::*;

   localparam step_kind_e KIND = pick_kind(STEP_VAL, STEP_WID);
   localparam int         CVAL = const_step(STEP_VAL);

   initial begin
      if (STEP_VAL > 0 && STEP_WID > 0)
         $error("step: fixed step and port width both given; width ignored");
      if (CVAL >= (1 << FIELD_W))
         $error("step: constant %0d does not fit the field", CVAL);
      if (KIND == STEP_PORT && STEP_WID > FIELD_W)
         $error("step: port width %0d wider than field", STEP_WID);
   end

   generate
      if (KIND == STEP_NONE) begin : g_none
         logic unused_in;
         assign unused_in = ^{req, amt};
         assign step      = '0;
         assign active    = 1'b0;
      end else if (KIND == STEP_CONST) begin : g_const
         logic unused_in;
         assign unused_in = ^amt;
         assign step      = (FIELD_W+1)'(CVAL);
         assign active    = req;
      end else begin : g_port
         assign step   = (FIELD_W+1)'(amt);
         assign active = req;
      end
   endgenerate

endmodule

// File: rtl/sud_next_calc.sv
module sud_next_calc #(
   parameter int                 FIELD_W = 4,
   parameter sud_pkg::sat_mode_e UP_SAT  = sud_pkg::SAT_OFF,
   parameter int                 UP_LIM  = 0,
   parameter sud_pkg::sat_mode_e LO_SAT  = sud_pkg::SAT_OFF,
   parameter int                 LO_LIM  = 0
) (
   input  logic [FIELD_W-1:0] cur,
   input  logic [FIELD_W:0]   inc_step,
   input  logic               inc_act,
   input  logic [FIELD_W:0]   dec_step,
   input  logic               dec_act,
   output logic [FIELD_W-1:0] nxt,
   output logic               upd
);
   import sud_pkg::*;

   localparam int EW    = FIELD_W + 2;
   localparam int UP_V  = upper_limit(UP_SAT, UP_LIM, FIELD_W);
   localparam int LO_V  = lower_limit(LO_SAT, LO_LIM);
   localparam logic signed [EW-1:0] UP_S = EW'(UP_V);
   localparam logic signed [EW-1:0] LO_S = EW'(LO_V);

   initial begin
      if (UP_SAT != SAT_OFF && (UP_V < 0 || UP_V >= (1 << FIELD_W)))
         $error("calc: upper limit %0d out of field range", UP_V);
      if (LO_SAT != SAT_OFF && (LO_V < 0 || LO_V >= (1 << FIELD_W)))
         $error("calc: lower limit %0d out of field range", LO_V);
   end

   logic signed [EW-1:0] add_term;
   logic signed [EW-1:0] sub_term;
   logic signed [EW-1:0] cand;
   logic                 up_ok;
   logic                 lo_ok;

   assign add_term = inc_act ? $signed({1'b0, inc_step}) : '0;
   assign sub_term = dec_act ? $signed({1'b0, dec_step}) : '0;
   assign cand     = $signed({2'b00, cur}) + add_term - sub_term;

   generate
      if (UP_SAT == SAT_OFF) begin : g_up_off
         assign up_ok = 1'b1;
      end else begin : g_up_on
         assign up_ok = (cand <= UP_S);
      end
      if (LO_SAT == SAT_OFF) begin : g_lo_off
         assign lo_ok = 1'b1;
      end else begin : g_lo_on
         assign lo_ok = (cand >= LO_S);
      end
   endgenerate

   always_comb begin
      upd = 1'b0;
      nxt = cur;
      if (inc_act || dec_act) begin
         if (up_ok && lo_ok) begin
            nxt = cand[FIELD_W-1:0];
            upd = 1'b1;
         end
      end
   end

endmodule

// File: rtl/sud_field_reg.sv
module sud_field_reg #(
   parameter int FIELD_W   = 4,
   parameter int RESET_VAL = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FIELD_W-1:0] d,
   output logic [FIELD_W-1:0] q
);

   initial begin
      if (RESET_VAL < 0 || RESET_VAL >= (1 << FIELD_W))
         $error("reg: reset value %0d does not fit", RESET_VAL);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= FIELD_W'(RESET_VAL);
      else if (load)
         q <= d;
   end

   a_r1_reset_value: assert property (@(posedge clk)
      !rst_n |=> q == FIELD_W'(RESET_VAL));

   a_r9_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

   a_r9_take_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(d));

endmodule

// File: rtl/sat_updown_field.sv
module sat_updown_field #(
   parameter int                 FIELD_W    = 4,
   parameter int                 INC_VALUE  = -1,
   parameter int                 INC_WIDTH  = 3,
   parameter int                 DEC_VALUE  = -1,
   parameter int                 DEC_WIDTH  = 0,
   parameter sud_pkg::sat_mode_e UP_SAT     = sud_pkg::SAT_VALUE,
   parameter int                 UP_LIMIT   = 13,
   parameter sud_pkg::sat_mode_e LO_SAT     = sud_pkg::SAT_FULL,
   parameter int                 LO_LIMIT   = 0,
   parameter int                 RESET_VAL  = 5,
   localparam int                INC_PORT_W = (INC_WIDTH > 0) ? INC_WIDTH : 1,
   localparam int                DEC_PORT_W = (DEC_WIDTH > 0) ? DEC_WIDTH : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  inc_req,
   input  logic [INC_PORT_W-1:0] inc_amt,
   input  logic                  dec_req,
   input  logic [DEC_PORT_W-1:0] dec_amt,
   output logic [FIELD_W-1:0]    value,
   output logic                  update
);
   import sud_pkg::*;

   localparam step_kind_e INC_KIND = pick_kind(INC_VALUE, INC_WIDTH);
   localparam step_kind_e DEC_KIND = pick_kind(DEC_VALUE, DEC_WIDTH);
   localparam int         UP_V     = upper_limit(UP_SAT, UP_LIMIT, FIELD_W);
   localparam int         LO_V     = lower_limit(LO_SAT, LO_LIMIT);

   initial begin
      if (FIELD_W < 1 || FIELD_W > 30)
         $error("field width %0d unsupported", FIELD_W);
      if (INC_KIND == STEP_NONE && DEC_KIND == STEP_NONE)
         $error("both count directions removed: illegal counter");
   end

   logic [FIELD_W:0]   inc_step;
   logic [FIELD_W:0]   dec_step;
   logic               inc_act;
   logic               dec_act;
   logic [FIELD_W-1:0] nxt;

   sud_step_sel #(
      .FIELD_W (FIELD_W), .STEP_VAL (INC_VALUE),
      .STEP_WID(INC_WIDTH), .PORT_W (INC_PORT_W)
   ) u_inc_sel (
      .req(inc_req), .amt(inc_amt), .step(inc_step), .active(inc_act)
   );

   sud_step_sel #(
      .FIELD_W (FIELD_W), .STEP_VAL (DEC_VALUE),
      .STEP_WID(DEC_WIDTH), .PORT_W (DEC_PORT_W)
   ) u_dec_sel (
      .req(dec_req), .amt(dec_amt), .step(dec_step), .active(dec_act)
   );

   sud_next_calc #(
      .FIELD_W(FIELD_W),
      .UP_SAT (UP_SAT), .UP_LIM(UP_LIMIT),
      .LO_SAT (LO_SAT), .LO_LIM(LO_LIMIT)
   ) u_calc (
      .cur     (value),
      .inc_step(inc_step), .inc_act(inc_act),
      .dec_step(dec_step), .dec_act(dec_act),
      .nxt     (nxt),      .upd    (update)
   );

   sud_field_reg #(
      .FIELD_W(FIELD_W), .RESET_VAL(RESET_VAL)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .load(update), .d(nxt), .q(value)
   );

   generate
      if (UP_SAT != SAT_OFF) begin : g_chk_up
         a_r6_upper_respected: assert property (@(posedge clk) disable iff (!rst_n)
            update |=> value <= FIELD_W'(UP_V));
      end
      if (LO_SAT != SAT_OFF) begin : g_chk_lo
         a_r7_lower_respected: assert property (@(posedge clk) disable iff (!rst_n)
            update |=> value >= FIELD_W'(LO_V));
      end
      if (INC_KIND == STEP_NONE) begin : g_chk_no_inc
         a_r4_inc_removed: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_req && !dec_req) |-> !update);
      end
      if (DEC_KIND == STEP_NONE) begin : g_chk_no_dec
         a_r4_dec_removed: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_req && !inc_req) |-> !update);
      end
   endgenerate

   a_r9_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_req && !dec_req) |-> !update);

endmodule

// File: tb/sat_updown_field_tb.sv
module sat_updown_field_tb;
   import sud_pkg::*;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n;
   logic       inc_req, dec_req;
   logic [2:0] inc_amt;
   logic [0:0] dec_amt;
   logic [3:0] value;
   logic       update;

   logic       w_inc, w_dec;
   logic [0:0] w_inc_amt, w_dec_amt;
   logic [3:0] w_value;
   logic       w_update;

   int n_chk = 0;
   int n_err = 0;

   sat_updown_field u_dut (
      .clk(clk), .rst_n(rst_n),
      .inc_req(inc_req), .inc_amt(inc_amt),
      .dec_req(dec_req), .dec_amt(dec_amt),
      .value(value), .update(update)
   );

   sat_updown_field #(
      .FIELD_W(4), .INC_VALUE(3), .INC_WIDTH(0),
      .DEC_VALUE(0), .DEC_WIDTH(0),
      .UP_SAT(SAT_OFF), .UP_LIMIT(0),
      .LO_SAT(SAT_OFF), .LO_LIMIT(0),
      .RESET_VAL(0)
   ) u_dut_wrap (
      .clk(clk), .rst_n(rst_n),
      .inc_req(w_inc), .inc_amt(w_inc_amt),
      .dec_req(w_dec), .dec_amt(w_dec_amt),
      .value(w_value), .update(w_update)
   );

   // {inc_req, inc_amt[2:0], dec_req, exp_update, exp_value[3:0]}, start value 5
   localparam logic [9:0] VEC [9] = '{
      {1'b1, 3'd3, 1'b0, 1'b1, 4'd8 },  // R3 port step
      {1'b1, 3'd5, 1'b0, 1'b1, 4'd13},  // R6 exactly at limit
      {1'b1, 3'd1, 1'b0, 1'b0, 4'd13},  // R6 blocked, no clamp
      {1'b0, 3'd0, 1'b1, 1'b1, 4'd12},  // R2 default step 1
      {1'b1, 3'd2, 1'b1, 1'b1, 4'd13},  // R8 combined
      {1'b1, 3'd1, 1'b1, 1'b1, 4'd13},  // R8 net zero at limit
      {1'b0, 3'd0, 1'b0, 1'b0, 4'd13},  // R9 idle holds
      {1'b1, 3'd0, 1'b0, 1'b1, 4'd13},  // R3 zero amount
      {1'b1, 3'd7, 1'b1, 1'b0, 4'd13}   // R8 combined over limit
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step_main(input logic i, input logic [2:0] a, input logic d,
                            input logic eu, input logic [3:0] ev, input string req);
      @(negedge clk);
      inc_req = i; inc_amt = a; dec_req = d;
      #1;
      check(req, int'(update), int'(eu));
      @(posedge clk);
      #1;
      check(req, int'(value), int'(ev));
   endtask

   task automatic step_wrap(input logic i, input logic d, input logic eu,
                            input logic [3:0] ev, input string req);
      @(negedge clk);
      w_inc = i; w_dec = d; w_inc_amt = 1'b1; w_dec_amt = 1'b1;
      #1;
      check(req, int'(w_update), int'(eu));
      @(posedge clk);
      #1;
      check(req, int'(w_value), int'(ev));
   endtask

   initial begin
      #(8 * 20000);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      inc_req = 1'b0; inc_amt = '0; dec_req = 1'b0; dec_amt = '0;
      w_inc = 1'b0; w_dec = 1'b0; w_inc_amt = '0; w_dec_amt = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset value", int'(value), 5);
      check("R1 reset value wrap", int'(w_value), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1 holds after release", int'(value), 5);

      for (int k = 0; k < 9; k++)
         step_main(VEC[k][9], VEC[k][8:6], VEC[k][5], VEC[k][4], VEC[k][3:0],
                   $sformatf("R8/R6/R3 vector %0d", k));

      // R7 walk down to the lower limit
      for (int k = 12; k >= 0; k--)
         step_main(1'b0, 3'd0, 1'b1, 1'b1, 4'(k), "R7 descend");
      step_main(1'b0, 3'd0, 1'b1, 1'b0, 4'd0, "R7 blocked below zero");
      step_main(1'b0, 3'd0, 1'b1, 1'b0, 4'd0, "R7 still held");
      step_main(1'b1, 3'd7, 1'b1, 1'b1, 4'd6, "R8 combined from zero");
      step_main(1'b1, 3'd7, 1'b0, 1'b1, 4'd13, "R6 jump to limit");

      // R1 synchronous reset during activity
      @(negedge clk);
      rst_n = 1'b0; inc_req = 1'b1; inc_amt = 3'd7;
      w_inc = 1'b1;
      @(posedge clk);
      #1;
      check("R1 reset overrides request", int'(value), 5);
      check("R1 reset overrides request wrap", int'(w_value), 0);
      @(negedge clk);
      rst_n = 1'b1; inc_req = 1'b0; inc_amt = '0; w_inc = 1'b0;

      // R4 removed decrement, R5 constant 3, R10 wrap
      step_wrap(1'b0, 1'b1, 1'b0, 4'd0, "R4 removed direction ignored");
      step_wrap(1'b1, 1'b0, 1'b1, 4'd3, "R5 constant step");
      step_wrap(1'b1, 1'b0, 1'b1, 4'd6, "R5 constant step");
      step_wrap(1'b1, 1'b0, 1'b1, 4'd9, "R5 constant step");
      step_wrap(1'b1, 1'b0, 1'b1, 4'd12, "R5 constant step");
      step_wrap(1'b1, 1'b0, 1'b1, 4'd15, "R10 top of range");
      step_wrap(1'b1, 1'b0, 1'b1, 4'd2, "R10 wrap modulo 16");
      step_wrap(1'b1, 1'b1, 1'b1, 4'd5, "R4 removed dec with inc");
      step_wrap(1'b0, 1'b0, 1'b0, 4'd5, "R9 idle holds");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule